// File: doc/BRIEF.md
# Idle Over-Current Fault Qualifier

This block decides whether a differential two-wire bus driver is in a genuine over-current fault while the bus is idle. It receives four limit-comparator flags, a sourcing-limit flag and a sinking-limit flag for each of the two lines A and B. A raw fault condition exists when both lines are caught at the sourcing limit together (both shorted toward ground) or both at the sinking limit together (both shorted toward the bus supply). The flags are asynchronous to the block clock and pass through a synchronizer first.

Two qualifying paths run in parallel while the bus is idle. A duration timer trips the block when the condition stays present for a continuous span (2.5 µs by default). An occurrence counter trips it when the condition starts a fixed number of times (four by default), with no quiet gap longer than a limit (50 µs by default) between consecutive starts. A trip sets a latched fault flag and a driver-disable output. Both stay set until the clear input or reset releases them. All spans are given in nanoseconds and converted to clock cycles from a clock-frequency parameter.

The control state machine has three states. OFF: not qualifying, counters held at zero. WATCH: bus idle, both paths active. TRIP: fault latched. The transitions are as follows. OFF goes to WATCH when idle is high. WATCH goes to TRIP when either path completes. If neither completes, WATCH goes to OFF when idle drops. TRIP goes to OFF on clear. The duration timer has the states CLEAR and RUN. The occurrence counter has the states EMPTY and COUNTING. COUNTING falls back to EMPTY when the gap expires or when watching stops.

Top module: `idle_oc_qualifier`

## Requirements
- R1: After reset, and until a trip, `fault_flag_o` and `drv_disable_o` are 0. The two outputs are equal in every cycle.
- R2: The raw condition is (A sourcing AND B sourcing) OR (A sinking AND B sinking). A mixed pair, such as A sourcing with B sinking, or one line alone, never trips the block.
- R3: The limit inputs pass through SYNC_STAGES flip-flops (default 2). A condition driven just before clock edge k is first sampled by the qualifiers at edge k+SYNC_STAGES.
- R4: While watching, a condition sampled high for CONT_CYC consecutive edges (625 at 250 MHz) trips the block at the last of those edges. CONT_CYC-1 consecutive samples do not trip it.
- R5: An occurrence is counted only on a low-to-high change of the sampled condition. A single long event (shorter than CONT_CYC) counts once.
- R6: While watching, the OCC_N-th occurrence (default 4) trips the block at the edge where it is sampled. This holds when each gap between consecutive occurrences is at most GAP_CYC low samples (12500 at 250 MHz).
- R7: GAP_CYC+1 consecutive low samples after an occurrence return the occurrence count to zero.
- R8: WATCH is entered only when `idle_i` is high. Leaving WATCH because `idle_i` dropped clears both qualifiers, so no trip can come from condition seen before that.
- R9: Once tripped, the outputs stay 1 whatever `idle_i` and the limit inputs do. A `clear_i` sampled high in TRIP returns both outputs to 0 at that edge.
- R10: `clear_i` in WATCH or OFF has no effect; occurrences counted so far are kept. After a release from TRIP, qualification starts again from zero counts.
- R11: If a path completes at the same edge where `clear_i` is high in WATCH, the trip wins and the outputs become 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_i | input | 1 | High while the bus is in idle mode |
| a_src_lim_i | input | 1 | Line A high-side sourcing-limit comparator (asynchronous) |
| b_src_lim_i | input | 1 | Line B high-side sourcing-limit comparator (asynchronous) |
| a_snk_lim_i | input | 1 | Line A low-side sinking-limit comparator (asynchronous) |
| b_snk_lim_i | input | 1 | Line B low-side sinking-limit comparator (asynchronous) |
| clear_i | input | 1 | Releases a latched fault |
| fault_flag_o | output | 1 | Latched idle current-limit fault flag |
| drv_disable_o | output | 1 | Disables the bus drivers while the fault is latched |

## Verification
The clear input and the completion of a qualifying path can land on the same clock edge, and that edge decides whether a fault is kept or lost. The bench holds a double-sourcing condition and raises clear for exactly one cycle so that it is sampled at the edge where the continuous-duration count reaches its limit. The expected result is a latched trip that persists afterwards. Clear pulses between counted occurrences show that the count survives a clear that falls outside TRIP. A behavioural per-cycle model judges every edge of both scenarios, alongside explicit checks of the final flag.

// File: rtl/oc_qual_pkg.sv
package oc_qual_pkg;

    typedef enum logic [1:0] {
        QS_OFF,
        QS_WATCH,
        QS_TRIP
    } qual_state_t;

    typedef enum logic {
        TS_CLEAR,
        TS_RUN
    } dur_state_t;

    typedef enum logic {
        OS_EMPTY,
        OS_COUNTING
    } occ_state_t;

    // Converts a span in nanoseconds to whole clock cycles, rounding up.
    function automatic int unsigned ns_to_cycles(input int unsigned clk_hz,
                                                 input int unsigned span_ns);
        longint unsigned prod;
        prod = 64'(clk_hz) * 64'(span_ns);
        return 32'((prod + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/oc_input_sync.sv
module oc_input_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/oc_duration_timer.sv
module oc_duration_timer
    import oc_qual_pkg::*;
#(
    parameter int unsigned  LIMIT = 625,
    localparam int unsigned CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          cond_i,
    output logic          done_o,
    output logic [CW-1:0] count_o
);

    dur_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          active;

    assign active = en_i & cond_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TS_CLEAR: begin
                if (active) begin
                    state_d = TS_RUN;
                    cnt_d   = CW'(1);
                end else begin
                    cnt_d   = '0;
                end
            end
            TS_RUN: begin
                if (!active) begin
                    state_d = TS_CLEAR;
                    cnt_d   = '0;
                end else if (cnt_q != CW'(LIMIT - 1)) begin
                    cnt_d   = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = TS_CLEAR;
                cnt_d   = '0;
            end
        endcase
    end

    // Completion: this sample is the LIMIT-th consecutive high one.
    always_comb begin
        done_o  = active && (state_q == TS_RUN) && (cnt_q == CW'(LIMIT - 1));
        count_o = cnt_q;
    end

endmodule

// File: rtl/oc_occurrence_counter.sv
module oc_occurrence_counter
    import oc_qual_pkg::*;
#(
    parameter int unsigned  OCC_N     = 4,
    parameter int unsigned  GAP_LIMIT = 12500,
    localparam int unsigned NW        = $clog2(OCC_N + 1),
    localparam int unsigned GW        = $clog2(GAP_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          cond_i,
    output logic          done_o,
    output logic [NW-1:0] count_o
);

    occ_state_t    state_q, state_d;
    logic [NW-1:0] num_q, num_d;
    logic [GW-1:0] gap_q, gap_d;
    logic          cond_prev_q;
    logic          rise;

    assign rise = cond_i & ~cond_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_prev_q <= 1'b0;
            state_q     <= OS_EMPTY;
            num_q       <= '0;
            gap_q       <= '0;
        end else begin
            cond_prev_q <= cond_i;
            state_q     <= state_d;
            num_q       <= num_d;
            gap_q       <= gap_d;
        end
    end

    always_comb begin
        state_d = state_q;
        num_d   = num_q;
        gap_d   = gap_q;
        unique case (state_q)
            OS_EMPTY: begin
                gap_d = '0;
                num_d = '0;
                if (en_i && rise) begin
                    state_d = OS_COUNTING;
                    num_d   = NW'(1);
                end
            end
            OS_COUNTING: begin
                if (!en_i) begin
                    state_d = OS_EMPTY;
                    num_d   = '0;
                    gap_d   = '0;
                end else if (rise) begin
                    if (num_q != NW'(OCC_N - 1)) num_d = num_q + NW'(1);
                    gap_d = '0;
                end else if (cond_i) begin
                    gap_d = '0;
                end else if (gap_q == GW'(GAP_LIMIT)) begin
                    state_d = OS_EMPTY;
                    num_d   = '0;
                    gap_d   = '0;
                end else begin
                    gap_d = gap_q + GW'(1);
                end
            end
            default: begin
                state_d = OS_EMPTY;
                num_d   = '0;
                gap_d   = '0;
            end
        endcase
    end

    always_comb begin
        done_o  = en_i && rise && (state_q == OS_COUNTING) && (num_q == NW'(OCC_N - 1));
        count_o = num_q;
    end

endmodule

// File: rtl/idle_oc_qualifier.sv
module idle_oc_qualifier
    import oc_qual_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 250_000_000,
    parameter int unsigned CONT_NS     = 2500,
    parameter int unsigned GAP_NS      = 50_000,
    parameter int unsigned OCC_N       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    input  logic a_src_lim_i,
    input  logic b_src_lim_i,
    input  logic a_snk_lim_i,
    input  logic b_snk_lim_i,
    input  logic clear_i,
    output logic fault_flag_o,
    output logic drv_disable_o
);

    localparam int unsigned CONT_CYC = ns_to_cycles(CLK_HZ, CONT_NS);
    localparam int unsigned GAP_CYC  = ns_to_cycles(CLK_HZ, GAP_NS);
    localparam int unsigned OCC_W    = $clog2(OCC_N + 1);
    localparam int unsigned RUN_W    = $clog2(CONT_CYC + 1);

    logic [3:0]       lim_raw, lim_s;
    logic             cond_s;
    logic             watch;
    logic             cont_done, occ_done, qualified;
    logic [OCC_W-1:0] occ_count;
    logic [RUN_W-1:0] run_count;

    qual_state_t state_q, state_d;

    assign lim_raw = {b_snk_lim_i, a_snk_lim_i, b_src_lim_i, a_src_lim_i};

    oc_input_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (lim_raw),
        .sync_o  (lim_s)
    );

    // Both lines pinned low (sourcing) or both pinned high (sinking).
    assign cond_s = (lim_s[0] & lim_s[1]) | (lim_s[2] & lim_s[3]);
    assign watch  = (state_q == QS_WATCH);

    oc_duration_timer #(
        .LIMIT (CONT_CYC)
    ) u_dur (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (watch),
        .cond_i  (cond_s),
        .done_o  (cont_done),
        .count_o (run_count)
    );

    oc_occurrence_counter #(
        .OCC_N     (OCC_N),
        .GAP_LIMIT (GAP_CYC)
    ) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (watch),
        .cond_i  (cond_s),
        .done_o  (occ_done),
        .count_o (occ_count)
    );

    assign qualified = cont_done | occ_done;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= QS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QS_OFF: begin
                if (idle_i) state_d = QS_WATCH;
            end
            QS_WATCH: begin
                if (qualified)    state_d = QS_TRIP;
                else if (!idle_i) state_d = QS_OFF;
            end
            QS_TRIP: begin
                if (clear_i) state_d = QS_OFF;
            end
            default: state_d = QS_OFF;
        endcase
    end

    always_comb begin
        unique case (state_q)
            QS_TRIP: begin
                fault_flag_o  = 1'b1;
                drv_disable_o = 1'b1;
            end
            default: begin
                fault_flag_o  = 1'b0;
                drv_disable_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/idle_oc_qualifier_chk.sv
module idle_oc_qualifier_chk #(
    parameter int unsigned OCC_N = 4,
    parameter int unsigned CNT_W = 3,
    parameter int unsigned RUN_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idle_i,
    input logic             clear_i,
    input logic             watch,
    input logic             cont_done,
    input logic             occ_done,
    input logic [CNT_W-1:0] occ_count,
    input logic [RUN_W-1:0] run_count,
    input logic             fault_flag_o
);

    // R9
    latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag_o && !clear_i |=> fault_flag_o);

    // R9
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag_o && clear_i |=> !fault_flag_o);

    // R4
    trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_flag_o) |-> $past(cont_done || occ_done));

    // R11
    trip_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        watch && (cont_done || occ_done) && clear_i |=> fault_flag_o);

    // R8
    watch_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(watch) |-> $past(idle_i));

    // R8
    idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !watch |=> (occ_count == '0) && (run_count == '0));

    // R6
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_count < CNT_W'(OCC_N));

endmodule

bind idle_oc_qualifier idle_oc_qualifier_chk #(
    .OCC_N (OCC_N),
    .CNT_W (OCC_W),
    .RUN_W (RUN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .idle_i       (idle_i),
    .clear_i      (clear_i),
    .watch        (watch),
    .cont_done    (cont_done),
    .occ_done     (occ_done),
    .occ_count    (occ_count),
    .run_count    (run_count),
    .fault_flag_o (fault_flag_o)
);

// File: tb/idle_oc_qualifier_tb.sv
`timescale 1ns/1ps
module idle_oc_qualifier_tb;

    localparam int CONT = 2500 * 250 / 1000;     // 2.5 us at 250 MHz
    localparam int GAP  = 50000 * 250 / 1000;    // 50 us at 250 MHz
    localparam int NOCC = 4;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle = 1'b0, clr = 1'b0;
    logic a_src = 1'b0, b_src = 1'b0, a_snk = 1'b0, b_snk = 1'b0;
    logic flag, dis;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    idle_oc_qualifier u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .idle_i        (idle),
        .a_src_lim_i   (a_src),
        .b_src_lim_i   (b_src),
        .a_snk_lim_i   (a_snk),
        .b_snk_lim_i   (b_snk),
        .clear_i       (clr),
        .fault_flag_o  (flag),
        .drv_disable_o (dis)
    );

    // Behavioural reference: 0 off, 1 watching, 2 tripped
    int m_st = 0, m_run = 0, m_occ = 0, m_gap = 0;
    bit m_prev = 1'b0;
    bit m_pipe[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_run = 0; m_occ = 0; m_gap = 0; m_prev = 1'b0;
            m_pipe = {};
            for (int i = 0; i < SYNC; i++) m_pipe.push_back(1'b0);
        end else begin
            bit c, rise, fin;
            c = m_pipe.pop_front();
            m_pipe.push_back((a_src && b_src) || (a_snk && b_snk));
            rise = c && !m_prev;
            m_prev = c;
            fin = 1'b0;
            if (m_st == 1) begin
                m_run = c ? m_run + 1 : 0;
                if (m_run >= CONT) fin = 1'b1;
                if (rise) begin
                    m_occ++; m_gap = 0;
                    if (m_occ >= NOCC) fin = 1'b1;
                end else if (!c && m_occ > 0) begin
                    m_gap++;
                    if (m_gap > GAP) begin m_occ = 0; m_gap = 0; end
                end
            end else begin
                m_run = 0; m_occ = 0; m_gap = 0;
            end
            case (m_st)
                0: if (idle) m_st = 1;
                1: if (fin) m_st = 2; else if (!idle) m_st = 0;
                default: if (clr) m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e;
            e = (m_st == 2);
            checks++;
            if (flag !== e || dis !== e) begin
                errors++;
                $display("FAIL %s cycle model: flag=%b dis=%b expected=%b at %0t",
                         cur_req, flag, dis, e, $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input bit e, input string req);
        checks++;
        if (flag !== e || dis !== e) begin
            errors++;
            $display("FAIL %s: flag=%b dis=%b expected=%b", req, flag, dis, e);
        end
    endtask

    task automatic set_src(input bit v);
        a_src = v; b_src = v;
    endtask

    task automatic pulse(input int hi, input int lo);
        set_src(1'b1); tick(hi);
        set_src(1'b0); tick(lo);
    endtask

    task automatic release_and_rearm();
        clr = 1'b1; tick(1); clr = 1'b0;
        idle = 1'b0; tick(4);
        idle = 1'b1; tick(4);
    endtask

    initial begin
        tick(3);
        expect_out(1'b0, "R1 in reset");
        rst_n = 1'b1;
        tick(2);
        expect_out(1'b0, "R1 after reset");
        idle = 1'b1; tick(4);

        // R2: mixed pairs and single lines never trip
        cur_req = "R2";
        a_src = 1'b1; b_snk = 1'b1; tick(1000);
        expect_out(1'b0, "R2 mixed pair");
        b_snk = 1'b0; tick(800);
        expect_out(1'b0, "R2 single line");
        a_src = 1'b0; tick(10);
        a_snk = 1'b1; b_snk = 1'b1; tick(700);
        expect_out(1'b1, "R2 both sinking");
        a_snk = 1'b0; b_snk = 1'b0;
        release_and_rearm();

        // R4: one sample short, then exact length; R3 latency
        cur_req = "R4";
        pulse(CONT - 1, 20);
        expect_out(1'b0, "R4 CONT-1 samples");
        release_and_rearm();
        cur_req = "R3";
        set_src(1'b1);
        tick(CONT + SYNC - 1);
        expect_out(1'b0, "R3 one edge before trip");
        tick(1);
        expect_out(1'b1, "R3 R4 trip after CONT plus sync");

        // R9: latched regardless of idle and inputs, clear releases
        cur_req = "R9";
        idle = 1'b0; tick(50);
        expect_out(1'b1, "R9 hold while not idle");
        set_src(1'b0); tick(50);
        expect_out(1'b1, "R9 hold with condition gone");
        clr = 1'b1; tick(1); clr = 1'b0;
        expect_out(1'b0, "R9 clear release");
        idle = 1'b1; tick(4);

        // R5/R6: long event counts once, fourth start trips
        cur_req = "R5";
        pulse(600, 1000); pulse(1, 1000); pulse(1, 1000);
        expect_out(1'b0, "R5 three occurrences");
        cur_req = "R6";
        pulse(1, 10);
        expect_out(1'b1, "R6 fourth occurrence");
        release_and_rearm();

        // R6 boundary: gaps of exactly GAP low samples
        for (int i = 0; i < NOCC - 1; i++) pulse(1, GAP);
        pulse(1, 10);
        expect_out(1'b1, "R6 gap at limit");
        release_and_rearm();

        // R7: gaps one sample too long
        cur_req = "R7";
        for (int i = 0; i < NOCC - 1; i++) pulse(1, GAP + 1);
        pulse(1, 10);
        expect_out(1'b0, "R7 gap over limit");
        release_and_rearm();

        // R8: no qualification outside idle; leaving idle clears counts
        cur_req = "R8";
        idle = 1'b0; set_src(1'b1); tick(2000);
        expect_out(1'b0, "R8 not idle long condition");
        set_src(1'b0); tick(5); idle = 1'b1; tick(5);
        for (int i = 0; i < NOCC - 1; i++) pulse(1, 100);
        idle = 1'b0; tick(3); idle = 1'b1; tick(3);
        pulse(1, 10);
        expect_out(1'b0, "R8 counts cleared by idle drop");
        release_and_rearm();

        // R10: clear while watching keeps count; requalify from zero
        cur_req = "R10";
        pulse(1, 100); pulse(1, 100);
        clr = 1'b1; tick(1); clr = 1'b0; tick(5);
        pulse(1, 100);
        pulse(1, 10);
        expect_out(1'b1, "R10 count kept across clear");
        clr = 1'b1; tick(1); clr = 1'b0; tick(4);
        for (int i = 0; i < NOCC - 1; i++) pulse(1, 100);
        expect_out(1'b0, "R10 requalify from zero");
        release_and_rearm();

        // R11: clear sampled at the trip edge
        cur_req = "R11";
        set_src(1'b1);
        tick(CONT + SYNC - 1);
        clr = 1'b1; tick(1); clr = 1'b0;
        expect_out(1'b1, "R11 trip wins over clear");
        tick(5);
        expect_out(1'b1, "R11 still latched");
        set_src(1'b0);
        tick(5);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: flag=%b expected run to complete", flag);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule